// File: doc/BRIEF.md
# Supply Supervisor with Watchdog Reset Sequencer

This block holds a system in reset while the supply is unusable and releases it only after a fixed settling delay. It also watches a heartbeat signal from the processor it supervises. It drives one active-high and one active-low system reset. Both come from a single register, so the pair never disagrees.

Two comparator flags describe the supply. One says the supply is below the lower trip point. The other says it is above the upper trip point. Because the two trip points differ, the supply sits in a dead band between them. The block measures all time in cycles of a free-running timebase.

One parameter, the unit length, sets every duration in a fixed 50:5:1 ratio:
- the power-on delay is 50 units;
- the watchdog window is 5 units;
- the watchdog reset pulse is 1 unit.

The watchdog is cleared only by a falling edge of the heartbeat, and it can be switched off with an enable pin.

Top module: `supervisor_wdt`

## Requirements
- R1: `sys_rst` and `sys_rst_n` are logical complements in every cycle.
- R2: While `rst_n` is low, and afterwards until `supply_above_hi` is sampled high, `sys_rst` is 1.
- R3: Once `supply_above_hi` is sampled high (with `supply_below_lo` low) in the supply-low state, `sys_rst` stays 1 for exactly 50×UNIT_CYC further cycles and then drops to 0.
- R4: Whenever `supply_below_lo` is sampled high, `sys_rst` is 1 from the next cycle, in any state. `supply_below_lo` takes priority over `supply_above_hi` when both are high.
- R5: After a supply drop, `sys_rst` stays 1 while neither flag is high. Only `supply_above_hi` starts a new power-on delay.
- R6: With `wd_en` high and no accepted heartbeat falling edge, `sys_rst` stays 0 for exactly 5×UNIT_CYC cycles after release and then rises.
- R7: A watchdog reset pulse lasts exactly UNIT_CYC cycles. The window then restarts from zero, so a missing heartbeat gives periodic pulses.
- R8: A heartbeat falling edge, after a SYNC_STAGES-flop synchronizer, restarts the window while reset is released. Rising edges do not restart it. A low or high phase of two timebase cycles is enough to be seen.
- R9: Heartbeat edges that occur while reset is asserted are ignored, and every window starts at zero when reset is released.
- R10: With `wd_en` low, the watchdog never asserts reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timebase |
| rst_n | input | 1 | Asynchronous active-low master reset |
| supply_above_hi | input | 1 | Supply is above the upper trip point (synchronous to clk) |
| supply_below_lo | input | 1 | Supply is below the lower trip point (synchronous to clk) |
| hbeat | input | 1 | Asynchronous heartbeat from the supervised processor |
| wd_en | input | 1 | High enables the watchdog, low disables it |
| sys_rst | output | 1 | System reset, active high |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
The bench builds the block with UNIT_CYC = 4 and the default two-stage synchronizer. This gives a 200-cycle power-on delay, a 20-cycle window and a 4-cycle pulse. With these short phases, thousands of random heartbeat toggles, supply drops and enable changes fit into a short run. Window expiry, heartbeat rescue just before expiry and repeated pulse trains all occur many times. The exact cycle boundaries of each phase are also measured directly.

// File: rtl/sup_pkg.sv
// Shared types for the supply supervisor.
// Assumes nothing beyond a single clock domain for the sequencer.
package sup_pkg;
    typedef enum logic [1:0] {
        ST_LOW = 2'd0,   // supply low, waiting for upper trip point
        ST_POR = 2'd1,   // power-on delay running
        ST_RUN = 2'd2,   // reset released, watchdog window running
        ST_WDR = 2'd3    // watchdog reset pulse
    } sup_st_e;
endpackage

// File: rtl/sup_hb_edge.sv
// Heartbeat synchronizer and falling-edge detector.
// Assumes the heartbeat's high and low phases each last at least two clk cycles.
module sup_hb_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hb_async,
    output logic hb_fall
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // First stage samples the asynchronous input.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= hb_async;
    end

    // Remaining stages form the synchronizer chain.
    generate
        for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    endgenerate

    // Holds the previous synchronized value for edge detection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    // A falling edge means high last cycle and low now.
    always_comb hb_fall = last_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/sup_seq.sv
// Reset sequencer. It moves between supply-low, power-on delay, run and
// watchdog-pulse states using one shared down-scaled counter.
// Assumes the supply flags are synchronous to clk.
module sup_seq
    import sup_pkg::*;
#(
    parameter int UNIT_CYC = 500000,
    parameter int CW       = $clog2(50 * UNIT_CYC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          above_hi,
    input  logic          below_lo,
    input  logic          wd_en,
    input  logic          hb_fall,
    output sup_st_e       st,
    output logic [CW-1:0] cnt,
    output logic          rst_q
);
    localparam logic [CW-1:0] POR_LAST = CW'(50 * UNIT_CYC - 1);
    localparam logic [CW-1:0] WIN_LAST = CW'(5 * UNIT_CYC - 1);
    localparam logic [CW-1:0] PUL_LAST = CW'(UNIT_CYC - 1);

    sup_st_e       st_nxt;
    logic [CW-1:0] cnt_nxt;

    // Next-state logic. A low supply overrides every other condition.
    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt + 1'b1;
        if (below_lo) begin
            st_nxt  = ST_LOW;
            cnt_nxt = '0;
        end else begin
            unique case (st)
                ST_LOW: begin
                    cnt_nxt = '0;
                    if (above_hi) st_nxt = ST_POR;
                end
                ST_POR: if (cnt == POR_LAST) begin
                    st_nxt  = ST_RUN;
                    cnt_nxt = '0;
                end
                ST_RUN: if (!wd_en || hb_fall) begin
                    cnt_nxt = '0;
                end else if (cnt == WIN_LAST) begin
                    st_nxt  = ST_WDR;
                    cnt_nxt = '0;
                end
                ST_WDR: if (cnt == PUL_LAST) begin
                    st_nxt  = ST_RUN;
                    cnt_nxt = '0;
                end
                default: begin
                    st_nxt  = ST_LOW;
                    cnt_nxt = '0;
                end
            endcase
        end
    end

    // State, counter and registered reset output.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_LOW;
            cnt   <= '0;
            rst_q <= 1'b1;
        end else begin
            st    <= st_nxt;
            cnt   <= cnt_nxt;
            rst_q <= (st_nxt != ST_RUN);
        end
    end
endmodule

// File: rtl/supervisor_wdt.sv
// Top of the supply supervisor. It joins the heartbeat edge detector and
// the sequencer, and drives a complementary reset pair from one flop.
// Assumes supply flags are synchronous and the heartbeat may be asynchronous.
module supervisor_wdt #(
    parameter int UNIT_CYC    = 500000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_above_hi,
    input  logic supply_below_lo,
    input  logic hbeat,
    input  logic wd_en,
    output logic sys_rst,
    output logic sys_rst_n
);
    localparam int CW = $clog2(50 * UNIT_CYC);

    sup_pkg::sup_st_e st;
    logic [CW-1:0]    cnt;
    logic             hb_fall;
    logic             rst_q;

    sup_hb_edge #(.SYNC_STAGES(SYNC_STAGES)) u_hb (
        .clk     (clk),
        .rst_n   (rst_n),
        .hb_async(hbeat),
        .hb_fall (hb_fall)
    );

    sup_seq #(.UNIT_CYC(UNIT_CYC), .CW(CW)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .above_hi(supply_above_hi),
        .below_lo(supply_below_lo),
        .wd_en   (wd_en),
        .hb_fall (hb_fall),
        .st      (st),
        .cnt     (cnt),
        .rst_q   (rst_q)
    );

    // Both outputs come from the same register.
    always_comb begin
        sys_rst   = rst_q;
        sys_rst_n = ~rst_q;
    end
endmodule

// File: rtl/sup_chk.sv
// Checker for the supervisor. It is bound to the top and watches ports
// and sequencer state.
module sup_chk
    import sup_pkg::*;
#(
    parameter int UNIT_CYC = 4,
    parameter int CW       = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          supply_above_hi,
    input logic          supply_below_lo,
    input logic          wd_en,
    input logic          hb_fall,
    input logic          sys_rst,
    input logic          sys_rst_n,
    input sup_st_e       st,
    input logic [CW-1:0] cnt
);
    a_r1_pair: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst != sys_rst_n);

    a_r2_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOW && !supply_above_hi) |=> (st == ST_LOW && sys_rst));

    a_r3_por_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_POR) |-> (int'(cnt) < 50 * UNIT_CYC));

    a_r4_drop: assert property (@(posedge clk) disable iff (!rst_n)
        supply_below_lo |=> (sys_rst && st == ST_LOW));

    a_r6_win_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN) |-> (int'(cnt) < 5 * UNIT_CYC));

    a_r7_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WDR) |-> (int'(cnt) < UNIT_CYC));

    a_r9_release_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst) |-> (cnt == '0));

    a_r10_wd_off: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && !wd_en && !supply_below_lo) |=> (st == ST_RUN));
endmodule

bind supervisor_wdt sup_chk #(.UNIT_CYC(UNIT_CYC), .CW(CW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .supply_above_hi(supply_above_hi),
    .supply_below_lo(supply_below_lo),
    .wd_en          (wd_en),
    .hb_fall        (hb_fall),
    .sys_rst        (sys_rst),
    .sys_rst_n      (sys_rst_n),
    .st             (st),
    .cnt            (cnt)
);

// File: tb/tb_supervisor_wdt.sv
module tb_supervisor_wdt;
    localparam int U   = 4;
    localparam int POR = 50 * U;
    localparam int WIN = 5 * U;
    localparam int PUL = U;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic above = 1'b0, below = 1'b0, hb = 1'b0, wden = 1'b1;
    logic sys_rst, sys_rst_n;
    int   n_chk = 0, n_bad = 0;
    bit   mon_on = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    supervisor_wdt #(.UNIT_CYC(U), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .supply_above_hi(above), .supply_below_lo(below),
        .hbeat(hb), .wd_en(wden), .sys_rst(sys_rst), .sys_rst_n(sys_rst_n)
    );

    // Reference model, built from the requirements: 0 low, 1 delay, 2 run, 3 pulse.
    int   m_st = 0, m_cnt = 0;
    logic m_s1 = 0, m_s2 = 0, m_prev = 0;

    function automatic bit exp_rst(int s);
        return s != 2;
    endfunction

    function automatic string tag_of(int s);
        case (s)
            0:       return "R5";
            1:       return "R3";
            2:       return "R6";
            default: return "R7";
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
        end else begin
            bit fall;
            fall   = m_prev && !m_s2;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = hb;
            if (below) begin
                m_st = 0; m_cnt = 0;
            end else case (m_st)
                0: begin m_cnt = 0; if (above) m_st = 1; end
                1: if (m_cnt == POR-1) begin m_st = 2; m_cnt = 0; end else m_cnt++;
                2: if (!wden || fall) m_cnt = 0;
                   else if (m_cnt == WIN-1) begin m_st = 3; m_cnt = 0; end
                   else m_cnt++;
                default: if (m_cnt == PUL-1) begin m_st = 2; m_cnt = 0; end else m_cnt++;
            endcase
        end
    end

    task automatic check(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) if (mon_on) begin
        check(sys_rst == exp_rst(m_st), tag_of(m_st), sys_rst, exp_rst(m_st));
        check(sys_rst_n == ~sys_rst, "R1", sys_rst_n, ~sys_rst);
    end

    // Count consecutive negedge samples with sys_rst equal to lvl.
    task automatic run_len(bit lvl, output int n);
        n = 0;
        while (sys_rst == lvl && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog timeout R2 actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        cyc(3);
        check(sys_rst == 1 && sys_rst_n == 0, "R2", sys_rst, 1);
        rst_n = 1'b1;
        mon_on = 1'b1;
        cyc(50);
        check(sys_rst == 1, "R2", sys_rst, 1);

        // R3: one-cycle flag, then exact power-on delay.
        above = 1; cyc(1); above = 0;
        run_len(1'b1, n);
        check(n == POR, "R3", n, POR);

        // R6/R7: window length, pulse length, periodic repetition.
        run_len(1'b0, n); check(n == WIN, "R6", n, WIN);
        run_len(1'b1, n); check(n == PUL, "R7", n, PUL);
        run_len(1'b0, n); check(n == WIN, "R7", n, WIN);

        // R8: heartbeat falls every 16 cycles keep the system out of reset.
        cyc(1);
        for (int i = 0; i < 20; i++) begin
            hb = 1; cyc(8); hb = 0; cyc(8);
            check(sys_rst == 0, "R8", sys_rst, 0);
        end
        // R8: rising edges alone do not rescue; hold high.
        hb = 1;
        run_len(1'b0, n);
        check(n > 0 && n <= WIN + 3, "R8", n, WIN);

        // R9: edges during the pulse are ignored; the window is full length.
        hb = 0; cyc(1); hb = 1;
        run_len(1'b1, n);
        run_len(1'b0, n); check(n == WIN, "R9", n, WIN);

        // R10: watchdog disabled.
        wden = 0; cyc(PUL + 2);
        for (int i = 0; i < 10; i++) begin
            cyc(30);
            check(sys_rst == 0, "R10", sys_rst, 0);
        end

        // R4: drop with both flags high; R5: dead band keeps reset.
        below = 1; above = 1; cyc(1);
        check(sys_rst == 1, "R4", sys_rst, 1);
        cyc(10); check(sys_rst == 1, "R4", sys_rst, 1);
        below = 0; above = 0; cyc(300);
        check(sys_rst == 1, "R5", sys_rst, 1);
        // R9: heartbeat activity during the delay does not shorten the window.
        wden = 1; above = 1; cyc(1); above = 0;
        for (int i = 0; i < 10; i++) begin hb = ~hb; cyc(5); end
        hb = 0;
        run_len(1'b1, n);
        run_len(1'b0, n); check(n == WIN, "R9", n, WIN);

        // Random phase compared cycle by cycle against the model.
        void'($urandom(32'hC0FFEE));
        for (int i = 0; i < 30000; i++) begin
            below = ($urandom_range(0, 1999) == 0);
            above = ($urandom_range(0, 49) == 0);
            if ($urandom_range(0, 5) == 0) hb = ~hb;
            if ($urandom_range(0, 999) == 0) wden = ~wden;
            cyc(1);
        end
        mon_on = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule